// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup

This block is the scheduling core of a small out-of-order processor. Renamed instructions arrive from decode one per cycle. Each one carries a unit class, two source tags with ready flags, and a destination tag. The block holds them in an eight-slot queue until both operands are resolved. Each cycle it sends the oldest ready instruction of each class to its execution unit. There are three classes: integer, memory and multiply.

Each unit is modelled only as a pipeline of destination tags, with a latency of 1, 3 or 4 cycles. When pipelines finish in the same cycle, a fixed-priority arbiter lets one of them broadcast its tag. The losers freeze and raise a stall. The tag is broadcast one cycle before the matching result strobe. That broadcast wakes waiting queue entries and the instruction being dispatched in the same cycle. A consumer can therefore issue in the very cycle its producer's tag appears.

Top module: `issue_queue_wakeup`

## Requirements
- R1: After reset the queue is empty: no issue strobe, no broadcast, no result strobe and no dispatch stall.
- R2: `dispStall` is high exactly when all 8 slots hold instructions. A dispatch offered while it is high is dropped.
- R3: An entry issues only when each source is either flagged ready or matches the tag broadcast in that same cycle. A consumer of a 1-cycle producer can therefore issue in the cycle after the producer.
- R4: A dispatched source whose tag equals the tag broadcast in the dispatch cycle is stored as ready.
- R5: Class codes are 0 integer, 1 memory and 2 multiply. Each cycle at most one instruction issues per class. Among ready entries of a class, the one dispatched earliest goes first.
- R6: Absent stalls, an instruction issued in cycle t has its destination tag broadcast in cycle t+1 (integer), t+3 (memory) or t+4 (multiply).
- R7: At most one tag is broadcast per cycle, with priority memory, then integer, then multiply. A finished unit that loses raises its stall, its pipeline holds, and nothing issues to it until it wins.
- R8: `rsltValid`/`rsltTag` repeat the broadcast of the previous cycle.
- R9: `flush` empties the queue in one cycle. A dispatch offered during flush is dropped, and nothing issues in the flush cycle or the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all queue entries |
| dispValid | input | 1 | Dispatch offer |
| dispClass | input | 2 | Unit class (0 int, 1 mem, 2 mul) |
| dispSrc1Tag | input | TAG_W | First source tag |
| dispSrc1Rdy | input | 1 | First source already resolved |
| dispSrc2Tag | input | TAG_W | Second source tag |
| dispSrc2Rdy | input | 1 | Second source already resolved |
| dispDstTag | input | TAG_W | Destination tag |
| dispStall | output | 1 | Queue full |
| intIssValid | output | 1 | Integer issue strobe |
| intIssDst | output | TAG_W | Destination tag of the integer issue |
| memIssValid | output | 1 | Memory issue strobe |
| memIssDst | output | TAG_W | Destination tag of the memory issue |
| mulIssValid | output | 1 | Multiply issue strobe |
| mulIssDst | output | TAG_W | Destination tag of the multiply issue |
| bcastValid | output | 1 | Completion tag broadcast |
| bcastTag | output | TAG_W | Broadcast tag |
| rsltValid | output | 1 | Result strobe, one cycle after the tag |
| rsltTag | output | TAG_W | Tag of that result |
| intStall | output | 1 | Integer unit lost arbitration |
| memStall | output | 1 | Memory unit lost arbitration |
| mulStall | output | 1 | Multiply unit lost arbitration |

## Verification
The assertions take for granted that `dispClass` never carries code 3, since such an entry would never issue. They also assume that `flush` and reset are the only ways to empty the queue. The stimulus draws classes only from 0 to 2 and keeps flush rare, so entries whose source tags never broadcast pile up until the queue fills. Directed sequences time a multiply, a memory and an integer instruction to finish in one cycle. They also release three waiting consumers on a single tag, and they offer a dispatch against a full queue and during a flush.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NUM_FU = 3;
  localparam int FU_INT = 0;
  localparam int FU_MEM = 1;
  localparam int FU_MUL = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              flush;
    logic              allocEn;
    logic [NUM_FU-1:0] issueEn;
  } iqStrobe_t;
endpackage

// File: rtl/iq_tag_pipe.sv
module iq_tag_pipe #(
  parameter int STAGES = 1,
  parameter int TAG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);
  logic [STAGES-1:0]            stVld;
  logic [STAGES-1:0][TAG_W-1:0] stTag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stVld <= '0;
      stTag <= '0;
    end else if (!hold) begin
      stVld[0] <= inValid;
      stTag[0] <= inTag;
      for (int k = 1; k < STAGES; k++) begin
        stVld[k] <= stVld[k-1];
        stTag[k] <= stTag[k-1];
      end
    end
  end

  assign outValid = stVld[STAGES-1];
  assign outTag   = stTag[STAGES-1];
endmodule

// File: rtl/iq_complete.sv
module iq_complete
  import iq_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int LAT_INT = 1,
  parameter int LAT_MEM = 3,
  parameter int LAT_MUL = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_FU-1:0]            issValid,
  input  logic [NUM_FU-1:0][TAG_W-1:0] issDst,
  output logic [NUM_FU-1:0]            unitStall,
  output logic                         bcastValid,
  output logic [TAG_W-1:0]             bcastTag,
  output logic                         rsltValid,
  output logic [TAG_W-1:0]             rsltTag
);
  localparam int LAT [NUM_FU] = '{LAT_INT, LAT_MEM, LAT_MUL};

  logic [NUM_FU-1:0]            tailValid;
  logic [NUM_FU-1:0][TAG_W-1:0] tailTag;
  logic [NUM_FU-1:0]            grant;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_pipe
    iq_tag_pipe #(.STAGES(LAT[u]), .TAG_W(TAG_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .hold(unitStall[u]),
      .inValid(issValid[u]), .inTag(issDst[u]),
      .outValid(tailValid[u]), .outTag(tailTag[u])
    );
  end

  // fixed priority: memory, integer, multiply
  always_comb begin
    grant = '0;
    if (tailValid[FU_MEM])      grant[FU_MEM] = 1'b1;
    else if (tailValid[FU_INT]) grant[FU_INT] = 1'b1;
    else if (tailValid[FU_MUL]) grant[FU_MUL] = 1'b1;
  end

  assign unitStall  = tailValid & ~grant;
  assign bcastValid = |grant;

  always_comb begin
    bcastTag = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (grant[u]) bcastTag = tailTag[u];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsltValid <= 1'b0;
      rsltTag   <= '0;
    end else begin
      rsltValid <= bcastValid;
      rsltTag   <= bcastTag;
    end
  end
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         dispValid,
  input  logic [DEPTH-1:0]             validVec,
  input  logic [NUM_FU-1:0][DEPTH-1:0] readyVec,
  input  logic [NUM_FU-1:0]            unitBusy,
  output iqStrobe_t                    strb,
  output logic [IDX_W-1:0]             allocIdx,
  output logic [NUM_FU-1:0][IDX_W-1:0] issueIdx,
  output logic [NUM_FU-1:0]            issValid,
  output logic                         dispStall
);
  // olderThan[i][j] set: entry j was dispatched before entry i
  logic [DEPTH-1:0][DEPTH-1:0] olderThan;

  assign dispStall = &validVec;

  always_comb begin
    allocIdx = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!validVec[i]) allocIdx = IDX_W'(i);
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_sel
    logic [DEPTH-1:0] pick;
    logic [IDX_W-1:0] pickIdx;
    always_comb begin
      pick    = '0;
      pickIdx = '0;
      for (int i = 0; i < DEPTH; i++)
        pick[i] = readyVec[u][i] && ((readyVec[u] & olderThan[i]) == '0);
      for (int i = 0; i < DEPTH; i++)
        if (pick[i]) pickIdx = IDX_W'(i);
    end
    assign issueIdx[u] = pickIdx;
    assign issValid[u] = (|readyVec[u]) && !unitBusy[u] && !flush;
  end

  assign strb.flush   = flush;
  assign strb.allocEn = dispValid && !dispStall && !flush;
  assign strb.issueEn = issValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olderThan <= '0;
    end else if (strb.allocEn) begin
      for (int j = 0; j < DEPTH; j++) olderThan[j][allocIdx] <= 1'b0;
      olderThan[allocIdx] <= validVec;
    end
  end
endmodule

// File: rtl/iq_datapath.sv
module iq_datapath
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  iqStrobe_t                    strb,
  input  logic [IDX_W-1:0]             allocIdx,
  input  logic [NUM_FU-1:0][IDX_W-1:0] issueIdx,
  input  logic [1:0]                   dispClass,
  input  logic [TAG_W-1:0]             dispSrc1Tag,
  input  logic                         dispSrc1Rdy,
  input  logic [TAG_W-1:0]             dispSrc2Tag,
  input  logic                         dispSrc2Rdy,
  input  logic [TAG_W-1:0]             dispDstTag,
  input  logic                         bcastValid,
  input  logic [TAG_W-1:0]             bcastTag,
  output logic [DEPTH-1:0]             validVec,
  output logic [NUM_FU-1:0][DEPTH-1:0] readyVec,
  output logic [NUM_FU-1:0][TAG_W-1:0] issDst
);
  logic [DEPTH-1:0]            vld, rdy1, rdy2, hit1, hit2;
  logic [DEPTH-1:0][1:0]       cls;
  logic [DEPTH-1:0][TAG_W-1:0] tag1, tag2, dTag;
  logic                        dispHit1, dispHit2;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit1[i] = bcastValid && (tag1[i] == bcastTag);
      hit2[i] = bcastValid && (tag2[i] == bcastTag);
    end
  end

  assign dispHit1 = bcastValid && (dispSrc1Tag == bcastTag);
  assign dispHit2 = bcastValid && (dispSrc2Tag == bcastTag);
  assign validVec = vld;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    always_comb begin
      for (int i = 0; i < DEPTH; i++)
        readyVec[u][i] = vld[i] && (cls[i] == 2'(u)) &&
                         (rdy1[i] || hit1[i]) && (rdy2[i] || hit2[i]);
    end
    assign issDst[u] = dTag[issueIdx[u]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      rdy1 <= '0;
      rdy2 <= '0;
      cls  <= '0;
      tag1 <= '0;
      tag2 <= '0;
      dTag <= '0;
    end else begin
      rdy1 <= rdy1 | hit1;
      rdy2 <= rdy2 | hit2;
      for (int u = 0; u < NUM_FU; u++)
        if (strb.issueEn[u]) vld[issueIdx[u]] <= 1'b0;
      if (strb.allocEn) begin
        vld[allocIdx]  <= 1'b1;
        cls[allocIdx]  <= dispClass;
        tag1[allocIdx] <= dispSrc1Tag;
        tag2[allocIdx] <= dispSrc2Tag;
        dTag[allocIdx] <= dispDstTag;
        rdy1[allocIdx] <= dispSrc1Rdy || dispHit1;
        rdy2[allocIdx] <= dispSrc2Rdy || dispHit2;
      end
      if (strb.flush) vld <= '0;
    end
  end
endmodule

// File: rtl/issue_queue_wakeup.sv
module issue_queue_wakeup
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 4,
  parameter int LAT_INT = 1,
  parameter int LAT_MEM = 3,
  parameter int LAT_MUL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             dispValid,
  input  logic [1:0]       dispClass,
  input  logic [TAG_W-1:0] dispSrc1Tag,
  input  logic             dispSrc1Rdy,
  input  logic [TAG_W-1:0] dispSrc2Tag,
  input  logic             dispSrc2Rdy,
  input  logic [TAG_W-1:0] dispDstTag,
  output logic             dispStall,
  output logic             intIssValid,
  output logic [TAG_W-1:0] intIssDst,
  output logic             memIssValid,
  output logic [TAG_W-1:0] memIssDst,
  output logic             mulIssValid,
  output logic [TAG_W-1:0] mulIssDst,
  output logic             bcastValid,
  output logic [TAG_W-1:0] bcastTag,
  output logic             rsltValid,
  output logic [TAG_W-1:0] rsltTag,
  output logic             intStall,
  output logic             memStall,
  output logic             mulStall
);
  localparam int IDX_W = $clog2(DEPTH);

  iqStrobe_t                    strb;
  logic [IDX_W-1:0]             allocIdx;
  logic [NUM_FU-1:0][IDX_W-1:0] issueIdx;
  logic [NUM_FU-1:0]            issValid, unitStall;
  logic [NUM_FU-1:0][TAG_W-1:0] issDst;
  logic [DEPTH-1:0]             validVec;
  logic [NUM_FU-1:0][DEPTH-1:0] readyVec;

  iq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dispValid(dispValid),
    .validVec(validVec), .readyVec(readyVec), .unitBusy(unitStall),
    .strb(strb), .allocIdx(allocIdx), .issueIdx(issueIdx),
    .issValid(issValid), .dispStall(dispStall)
  );

  iq_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .allocIdx(allocIdx),
    .issueIdx(issueIdx), .dispClass(dispClass),
    .dispSrc1Tag(dispSrc1Tag), .dispSrc1Rdy(dispSrc1Rdy),
    .dispSrc2Tag(dispSrc2Tag), .dispSrc2Rdy(dispSrc2Rdy),
    .dispDstTag(dispDstTag), .bcastValid(bcastValid), .bcastTag(bcastTag),
    .validVec(validVec), .readyVec(readyVec), .issDst(issDst)
  );

  iq_complete #(.TAG_W(TAG_W), .LAT_INT(LAT_INT), .LAT_MEM(LAT_MEM),
                .LAT_MUL(LAT_MUL)) u_cmpl (
    .clk(clk), .rst_n(rst_n), .issValid(issValid), .issDst(issDst),
    .unitStall(unitStall), .bcastValid(bcastValid), .bcastTag(bcastTag),
    .rsltValid(rsltValid), .rsltTag(rsltTag)
  );

  assign intIssValid = issValid[FU_INT];
  assign memIssValid = issValid[FU_MEM];
  assign mulIssValid = issValid[FU_MUL];
  assign intIssDst   = issDst[FU_INT];
  assign memIssDst   = issDst[FU_MEM];
  assign mulIssDst   = issDst[FU_MUL];
  assign intStall    = unitStall[FU_INT];
  assign memStall    = unitStall[FU_MEM];
  assign mulStall    = unitStall[FU_MUL];
endmodule

// File: rtl/iq_wakeup_chk.sv
module iq_wakeup_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             intIssValid,
  input logic [TAG_W-1:0] intIssDst,
  input logic             memIssValid,
  input logic             mulIssValid,
  input logic             bcastValid,
  input logic [TAG_W-1:0] bcastTag,
  input logic             rsltValid,
  input logic [TAG_W-1:0] rsltTag,
  input logic             intStall,
  input logic             memStall,
  input logic             mulStall
);
  // R7
  mem_never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memStall);
  // R7
  int_stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intStall |-> (bcastValid && !intIssValid));
  // R7
  mul_stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mulStall |-> (bcastValid && !mulIssValid));
  // R6
  int_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intIssValid |=> ((bcastValid && bcastTag == $past(intIssDst)) || intStall));
  // R8
  rslt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcastValid |=> (rsltValid && rsltTag == $past(bcastTag)));
  // R8
  rslt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bcastValid |=> !rsltValid);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(intIssValid || memIssValid || mulIssValid));
endmodule

bind issue_queue_wakeup iq_wakeup_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .intIssValid(intIssValid), .intIssDst(intIssDst),
  .memIssValid(memIssValid), .mulIssValid(mulIssValid),
  .bcastValid(bcastValid), .bcastTag(bcastTag),
  .rsltValid(rsltValid), .rsltTag(rsltTag),
  .intStall(intStall), .memStall(memStall), .mulStall(mulStall)
);

// File: tb/issue_queue_wakeup_bench.sv
`timescale 1ns/1ps
module issue_queue_wakeup_bench;
  localparam int DEPTH = 8;
  localparam int TAG_W = 4;
  localparam int LAT [3] = '{1, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic dispValid = 1'b0;
  logic [1:0] dispClass = '0;
  logic [TAG_W-1:0] dispSrc1Tag = '0, dispSrc2Tag = '0, dispDstTag = '0;
  logic dispSrc1Rdy = 1'b0, dispSrc2Rdy = 1'b0;
  logic dispStall, intIssValid, memIssValid, mulIssValid;
  logic [TAG_W-1:0] intIssDst, memIssDst, mulIssDst, bcastTag, rsltTag;
  logic bcastValid, rsltValid, intStall, memStall, mulStall;

  always #5 clk = ~clk;

  issue_queue_wakeup #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_issue_queue_wakeup (.*);

  int testCnt = 0;
  int failCnt = 0;

  // independent model state
  int mV[DEPTH], mCls[DEPTH], mT1[DEPTH], mR1[DEPTH], mT2[DEPTH], mR2[DEPTH];
  int mD[DEPTH], mSeq[DEPTH];
  int pv[3][4], pt[3][4];
  int seqCnt = 0;
  int prevBV = 0, prevBT = 0;

  task automatic check(input int act, input int exp, input string req, input string what,
                       input string phase);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s (%s): actual=%0d expected=%0d", req, what, phase, act, exp);
    end
  endtask

  function automatic int srcOk(input int r, input int t, input int bv, input int bt);
    return (r != 0) || (bv != 0 && t == bt);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mV[i] = 0;
    for (int u = 0; u < 3; u++) for (int k = 0; k < 4; k++) begin pv[u][k] = 0; pt[u][k] = 0; end
    prevBV = 0; prevBT = 0;
  endtask

  // one cycle: drive, compare against model, advance model
  task automatic step(input int dv, input int cls, input int t1, input int r1, input int t2,
                      input int r2, input int d, input int fl, input string phase);
    int tailV[3], tailT[3], eSt[3], eIss[3], eDst[3];
    int g, eBV, eBT, cnt;
    @(negedge clk);
    dispValid = dv[0]; dispClass = 2'(cls); dispSrc1Tag = TAG_W'(t1); dispSrc1Rdy = r1[0];
    dispSrc2Tag = TAG_W'(t2); dispSrc2Rdy = r2[0]; dispDstTag = TAG_W'(d); flush = fl[0];
    #1;
    for (int u = 0; u < 3; u++) begin tailV[u] = pv[u][LAT[u]-1]; tailT[u] = pt[u][LAT[u]-1]; end
    g = -1;
    if (tailV[1] != 0) g = 1; else if (tailV[0] != 0) g = 0; else if (tailV[2] != 0) g = 2;
    eBV = (g >= 0); eBT = (g >= 0) ? tailT[g] : 0;
    cnt = 0;
    for (int i = 0; i < DEPTH; i++) cnt += mV[i];
    for (int u = 0; u < 3; u++) begin
      int best;
      best = -1;
      eSt[u] = (tailV[u] != 0 && g != u);
      if (eSt[u] == 0 && fl == 0)
        for (int i = 0; i < DEPTH; i++)
          if (mV[i] != 0 && mCls[i] == u && srcOk(mR1[i], mT1[i], eBV, eBT) != 0 &&
              srcOk(mR2[i], mT2[i], eBV, eBT) != 0 && (best < 0 || mSeq[i] < mSeq[best]))
            best = i;
      eIss[u] = (best >= 0); eDst[u] = (best >= 0) ? mD[best] : 0;
      if (best >= 0) mV[best] = 0;
    end
    check(int'(dispStall), int'(cnt == DEPTH), "R2", "dispStall", phase);
    check(int'(intIssValid), eIss[0], "R5", "intIssValid", phase);
    check(int'(memIssValid), eIss[1], "R5", "memIssValid", phase);
    check(int'(mulIssValid), eIss[2], "R5", "mulIssValid", phase);
    if (eIss[0] != 0) check(int'(intIssDst), eDst[0], "R5", "intIssDst", phase);
    if (eIss[1] != 0) check(int'(memIssDst), eDst[1], "R5", "memIssDst", phase);
    if (eIss[2] != 0) check(int'(mulIssDst), eDst[2], "R5", "mulIssDst", phase);
    check(int'(bcastValid), eBV, "R6", "bcastValid", phase);
    if (eBV != 0) check(int'(bcastTag), eBT, "R6", "bcastTag", phase);
    check(int'(intStall), eSt[0], "R7", "intStall", phase);
    check(int'(memStall), eSt[1], "R7", "memStall", phase);
    check(int'(mulStall), eSt[2], "R7", "mulStall", phase);
    check(int'(rsltValid), prevBV, "R8", "rsltValid", phase);
    if (prevBV != 0) check(int'(rsltTag), prevBT, "R8", "rsltTag", phase);
    // advance model to the next edge
    for (int u = 0; u < 3; u++)
      if (eSt[u] == 0) begin
        for (int k = LAT[u]-1; k > 0; k--) begin pv[u][k] = pv[u][k-1]; pt[u][k] = pt[u][k-1]; end
        pv[u][0] = eIss[u]; pt[u][0] = eDst[u];
      end
    for (int i = 0; i < DEPTH; i++) begin
      if (srcOk(0, mT1[i], eBV, eBT) != 0) mR1[i] = 1;
      if (srcOk(0, mT2[i], eBV, eBT) != 0) mR2[i] = 1;
    end
    if (fl != 0) begin
      for (int i = 0; i < DEPTH; i++) mV[i] = 0;
    end else if (dv != 0 && cnt < DEPTH) begin
      for (int i = 0; i < DEPTH; i++)
        if (mV[i] == 0) begin
          mV[i] = 1; mCls[i] = cls; mT1[i] = t1; mT2[i] = t2; mD[i] = d;
          mR1[i] = srcOk(r1, t1, eBV, eBT); mR2[i] = srcOk(r2, t2, eBV, eBT);
          mSeq[i] = seqCnt++;
          break;
        end
    end
    prevBV = eBV; prevBT = eBT;
  endtask

  task automatic idle(input int n, input string phase);
    for (int k = 0; k < n; k++) step(0, 0, 0, 1, 0, 1, 0, 0, phase);
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: idle after reset
    idle(2, "R1");
    // R3: back-to-back integer dependency
    step(1, 0, 0, 1, 0, 1, 1, 0, "R3");
    step(1, 0, 1, 0, 0, 1, 2, 0, "R3");
    idle(4, "R3");
    // R4: consumers dispatched around the multiply broadcast of tag 5
    step(1, 2, 0, 1, 0, 1, 5, 0, "R4");
    for (int k = 0; k < 6; k++) step(1, 0, 5, 0, 0, 1, 6 + k, 0, "R4");
    idle(6, "R4");
    // R7: multiply, memory and integer finish in one cycle
    step(1, 2, 0, 1, 0, 1, 3, 0, "R7");
    step(1, 1, 0, 1, 0, 1, 4, 0, "R7");
    idle(1, "R7");
    step(1, 0, 0, 1, 0, 1, 7, 0, "R7");
    idle(8, "R7");
    // R2: fill with entries waiting on tag 15, then offer more
    for (int k = 0; k < 10; k++) step(1, k % 3, 15, 0, 0, 1, k, 0, "R2");
    // R9: flush with a dispatch offered, then nothing issues
    step(1, 0, 0, 1, 0, 1, 9, 1, "R9");
    idle(2, "R9");
    // R5: three integer consumers released together by tag 9
    step(1, 2, 0, 1, 0, 1, 9, 0, "R5");
    for (int k = 0; k < 3; k++) step(1, 0, 9, 0, 9, 0, 10 + k, 0, "R5");
    idle(8, "R5");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int fl;
      fl = ($urandom_range(99) == 0) ? 1 : 0;
      step(int'($urandom_range(99) < 70), int'($urandom_range(2)),
           int'($urandom_range(15)), int'($urandom_range(9) < 6),
           int'($urandom_range(15)), int'($urandom_range(9) < 6),
           int'($urandom_range(15)), fl, "random");
    end
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule